// File: doc/BRIEF.md
# Decimal Thumbwheel Base-Address Scanner

This block derives a binary base address from three decimal thumbwheel switches that share one 4-bit return bus. It pulls down one digit-select line at a time. It waits a fixed number of clocks so the switch contacts can settle, and then captures the bus. The switches pull the bus low for a set bit, so every captured nibble is inverted. The three digits are read in the order hundreds, tens, units.

When the units digit has been captured, the block weights the digits and subtracts one. It then publishes the result to a downstream frame receiver in a single clock, with a one-clock update pulse. The receiver can therefore latch a new address at any moment and never sees a mix of an old and a new value. The scan runs continuously: after each publish the bus sits idle for a programmable gap, and then the next scan starts. A setting of 000 gives the all-ones address, which a receiver reads as a slot number past the end of any frame.

Top module: `thumb_addr_reader`

## Requirements
- R1: The select outputs `digitEnN` are active-low: bit 2 selects hundreds, bit 1 selects tens and bit 0 selects units. No more than one of them is low in any cycle.
- R2: A scan drives hundreds, then tens, then units. Each select is held low for exactly SETTLE_CYC consecutive clocks, and the bus is captured at the clock edge that ends that window.
- R3: The captured digit is the bitwise inverse of the 4-bit `swBusN` value present during the last clock of its select window.
- R4: The published address equals (100·hundreds + 10·tens + units − 1) modulo 2^ADDR_W, with carries and borrows propagated across the full width.
- R5: A switch setting of 000 publishes the all-ones address (1023 at the default width).
- R6: `addrUpdate` is high for exactly one clock, in the first cycle after a complete three-digit scan. `baseAddr` changes only in a cycle where `addrUpdate` is high.
- R7: While `rstN` is low, all selects are high, `baseAddr` is all ones and `addrUpdate` is low.
- R8: Scanning repeats. After each publish cycle the selects stay high for GAP_CYC clocks before the hundreds select is pulled low again. The first scan after reset also starts after GAP_CYC idle clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| digitEnN | output | 3 | Active-low digit selects: [2] hundreds, [1] tens, [0] units |
| swBusN | input | 4 | Shared active-low switch return bus |
| baseAddr | output | ADDR_W | Published base address |
| addrUpdate | output | 1 | One-clock pulse when baseAddr is republished |

## Verification
The switches are given settings that separate the three digit weights: 001 and 000 exercise the minus-one correction and its wrap to all ones, and 999 is the largest value. The setting 512 carries across the byte boundary, and 100 and 090 each isolate a single weight. During one scan the hundreds digit is changed partway through its settle window, so the value seen at the window's last clock must win over the earlier one. The switch model drives the bus only for the selected digit, so any capture of the wrong digit or at the wrong time shows up as a wrong address.

// File: rtl/thumb_pkg.sv
package thumb_pkg;
  localparam int DIGIT_W = 4;
  localparam int NUM_DIGITS = 3;

  typedef enum logic [2:0] {
    ST_GAP,
    ST_HUND,
    ST_TENS,
    ST_UNITS,
    ST_PUB
  } scanState_t;

  typedef struct packed {
    logic capHund;
    logic capTens;
    logic capUnits;
    logic publish;
  } scanStrobes_t;
endpackage

// File: rtl/thumb_scan_ctrl.sv
module thumb_scan_ctrl
  import thumb_pkg::*;
#(
  parameter int SETTLE_CYC = 16,
  parameter int GAP_CYC = 1000
) (
  input  logic clk,
  input  logic rstN,
  output logic [NUM_DIGITS-1:0] digitEnN,
  output scanStrobes_t strobes
);
  localparam int MAX_CNT = (SETTLE_CYC > GAP_CYC) ? SETTLE_CYC : GAP_CYC;
  localparam int CNT_W = $clog2(MAX_CNT + 1);

  scanState_t state;
  logic [CNT_W-1:0] cnt;
  logic settleDone;
  logic gapDone;

  assign settleDone = (cnt == CNT_W'(SETTLE_CYC - 1));
  assign gapDone = (cnt == CNT_W'(GAP_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_GAP;
      cnt <= '0;
    end else begin
      case (state)
        ST_GAP: begin
          if (gapDone) begin
            state <= ST_HUND;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HUND, ST_TENS, ST_UNITS: begin
          if (settleDone) begin
            cnt <= '0;
            if (state == ST_HUND) state <= ST_TENS;
            else if (state == ST_TENS) state <= ST_UNITS;
            else state <= ST_PUB;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= ST_GAP;
          cnt <= '0;
        end
      endcase
    end
  end

  always_comb begin
    digitEnN = '1;
    case (state)
      ST_HUND: digitEnN[2] = 1'b0;
      ST_TENS: digitEnN[1] = 1'b0;
      ST_UNITS: digitEnN[0] = 1'b0;
      default: digitEnN = '1;
    endcase
  end

  always_comb begin
    strobes.capHund = (state == ST_HUND) && settleDone;
    strobes.capTens = (state == ST_TENS) && settleDone;
    strobes.capUnits = (state == ST_UNITS) && settleDone;
    strobes.publish = (state == ST_PUB);
  end

  // R1: at most one select active
  assert_one_select_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~digitEnN));
  // R2: tens follows hundreds directly
  assert_tens_after_hund_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(digitEnN[1]) |-> !$past(digitEnN[2]));
  // R2: units follows tens directly
  assert_units_after_tens_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(digitEnN[0]) |-> !$past(digitEnN[1]));
  // R8: hundreds starts only from the idle gap
  assert_hund_from_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(digitEnN[2]) |-> ($past(digitEnN) == 3'b111));
endmodule

// File: rtl/thumb_addr_dp.sv
module thumb_addr_dp
  import thumb_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic clk,
  input  logic rstN,
  input  scanStrobes_t strobes,
  input  logic [DIGIT_W-1:0] swBusN,
  output logic [ADDR_W-1:0] baseAddr,
  output logic addrUpdate
);
  logic [NUM_DIGITS-1:0] capVec;
  logic [DIGIT_W-1:0] digitQ [NUM_DIGITS];
  logic [ADDR_W-1:0] weighted [NUM_DIGITS];
  logic [ADDR_W-1:0] nextAddr;

  assign capVec = {strobes.capHund, strobes.capTens, strobes.capUnits};

  function automatic int digitWeight(input int idx);
    int w;
    w = 1;
    for (int k = 0; k < idx; k++) w = w * 10;
    return w;
  endfunction

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : gDigit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) digitQ[g] <= '0;
      else if (capVec[g]) digitQ[g] <= ~swBusN;
    end
    assign weighted[g] = ADDR_W'(digitQ[g]) * ADDR_W'(digitWeight(g));
  end

  assign nextAddr = weighted[2] + weighted[1] + weighted[0] - ADDR_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr <= '1;
      addrUpdate <= 1'b0;
    end else begin
      addrUpdate <= strobes.publish;
      if (strobes.publish) baseAddr <= nextAddr;
    end
  end

  // R6: address moves only together with the update pulse
  assert_atomic_publish_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(baseAddr) |-> addrUpdate);
  // R6: update pulse lasts one clock
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    addrUpdate |=> !addrUpdate);
endmodule

// File: rtl/thumb_addr_reader.sv
module thumb_addr_reader
  import thumb_pkg::*;
#(
  parameter int SETTLE_CYC = 16,
  parameter int GAP_CYC = 1000,
  parameter int ADDR_W = 10
) (
  input  logic clk,
  input  logic rstN,
  output logic [2:0] digitEnN,
  input  logic [3:0] swBusN,
  output logic [ADDR_W-1:0] baseAddr,
  output logic addrUpdate
);
  scanStrobes_t strobes;

  thumb_scan_ctrl #(.SETTLE_CYC(SETTLE_CYC), .GAP_CYC(GAP_CYC)) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .digitEnN(digitEnN),
    .strobes(strobes)
  );

  thumb_addr_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .swBusN(swBusN),
    .baseAddr(baseAddr),
    .addrUpdate(addrUpdate)
  );
endmodule

// File: tb/thumb_addr_reader_bench.sv
module thumb_addr_reader_bench;
  localparam int S = 4;
  localparam int G = 10;
  localparam int AW = 10;
  localparam int P = G + 3 * S + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] digitEnN;
  logic [3:0] swBusN;
  logic [AW-1:0] baseAddr;
  logic addrUpdate;
  logic [3:0] setH = 4'd0, setT = 4'd0, setU = 4'd0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  // switch model: only the selected wheel drives the shared bus
  assign swBusN = !digitEnN[2] ? ~setH : !digitEnN[1] ? ~setT : !digitEnN[0] ? ~setU : 4'hF;

  thumb_addr_reader #(.SETTLE_CYC(S), .GAP_CYC(G), .ADDR_W(AW)) u_thumb_addr_reader (
    .clk(clk), .rstN(rstN), .digitEnN(digitEnN), .swBusN(swBusN),
    .baseAddr(baseAddr), .addrUpdate(addrUpdate)
  );

  int patH [8] = '{0, 0, 9, 5, 1, 0, 3, 2};
  int patT [8] = '{0, 0, 9, 1, 0, 9, 4, 5};
  int patU [8] = '{1, 0, 9, 2, 0, 0, 7, 6};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int expEnables(input int p);
    if (p < G) return 7;
    if (p < G + S) return 3;
    if (p < G + 2 * S) return 5;
    if (p < G + 3 * S) return 6;
    return 7;
  endfunction

  initial begin
    int cyc, p, scanIdx, expAddr, expStrobe, mh, mt, mu;
    string addrTag;
    expAddr = 1023; expStrobe = 0; scanIdx = 0; mh = 0; mt = 0; mu = 0;
    addrTag = "R7";
    // R7: reset state
    repeat (3) begin
      @(negedge clk);
      check("R7 enables", int'(digitEnN), 7);
      check("R7 address", int'(baseAddr), 1023);
      check("R7 strobe", int'(addrUpdate), 0);
    end
    rstN = 1'b1;
    for (cyc = 0; cyc < 9 * P + 3; cyc++) begin
      p = cyc % P;
      check("R1 R2 R8 enables", int'(digitEnN), expEnables(p));
      check({addrTag, " address"}, int'(baseAddr), expAddr);
      check("R6 R8 strobe", int'(addrUpdate), expStrobe);
      // stimulus: new setting at the start of each period
      if (p == 0 && scanIdx < 8) begin
        setH = 4'(patH[scanIdx]); setT = 4'(patT[scanIdx]); setU = 4'(patU[scanIdx]);
        scanIdx++;
      end
      // R2 R3: change hundreds inside its window; last-cycle value must win
      if (scanIdx == 7 && p == G + 1) setH = 4'd6;
      // reference model for the coming edge
      if (p == G + S - 1) mh = int'(setH);
      if (p == G + 2 * S - 1) mt = int'(setT);
      if (p == G + 3 * S - 1) mu = int'(setU);
      expStrobe = (p == G + 3 * S) ? 1 : 0;
      if (p == G + 3 * S) begin
        expAddr = (100 * mh + 10 * mt + mu - 1 + 1024) % 1024;
        addrTag = (mh == 0 && mt == 0 && mu == 0) ? "R5" : "R3 R4";
      end
      @(negedge clk);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule